// File: doc/BRIEF.md
# Clock Control and Oscillator-Stop Register Unit

This block is the register slice of a clock generator. It holds two byte-wide registers on a simple synchronous bus: a PLL control register whose only live bit asks for the PLL to stop, and a detection register. The detection register holds an enable for main-oscillator stop detection, a sticky stop-detected flag and a read-only live monitor of the oscillator state. The analog oscillators, the PLL, the base clock multiplexer and the clock switch are outside the block.

Every write passes two gates. An external unlock input must be 1 or the write is dropped. A clock-change lock input freezes the PLL stop bit and the detection enable. The "oscillator stopped" input is asynchronous. It goes through a two-flop synchronizer, and its rising edge, when detection is enabled, counts as a stop event. A stop event sets the sticky flag and gives a one-clock interrupt pulse. Software clears the flag by writing 0. While the oscillator stays stopped the flag does not come back. It sets again only on a new stop event.

Top module: `clkctl_regs`

## Requirements
- R1: After reset the PLL register reads 0x20 (address 0x40047) and the detection register reads 0x00 (address 0x4004D); any other address reads 0x00.
- R2: In the PLL register, bit 0 holds the stop request, bit 5 always reads 1 and the other bits always read 0. In the detection register, bit 0 is the detection enable, bit 2 is the stop flag and bit 3 is the monitor. Bits 1 and 7..4 always read 0.
- R3: pll_en is 1 whenever the PLL stop bit is 0 or pll_is_base is 1, and is 0 otherwise.
- R4: A write with wr_unlock at 0 changes no register bit.
- R5: With chg_lock at 1, a write leaves the PLL stop bit and the detection enable unchanged.
- R6: An unlocked write to the detection register with bit 2 at 0 clears the flag, including under chg_lock. Writing 1 to bit 2 never sets the flag.
- R7: A rising edge of osc_stopped with detection enabled sets the flag and pulses stop_irq for exactly one clock. Both appear 3 clock edges after the input rises.
- R8: A flag cleared while the oscillator is still stopped stays 0 until the input falls and rises again.
- R9: The monitor bit (detection register bit 3) shows osc_stopped 2 clock edges after it changes.
- R10: A clearing write in the same cycle as a stop event leaves the flag set.
- R11: With detection disabled, a rising osc_stopped sets no flag and gives no stop_irq pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| wr_unlock | input | 1 | Write protection release (1 = writes allowed) |
| chg_lock | input | 1 | Clock-change lock for the stop and enable bits |
| pll_is_base | input | 1 | PLL is the active base clock source |
| osc_stopped | input | 1 | Asynchronous main-oscillator-stopped status |
| pll_en | output | 1 | PLL run enable |
| stop_irq | output | 1 | One-clock stop-detect interrupt |

## Verification
Register writes show on the combinational read port one edge after the strobe, so the bench drives on the falling edge and reads back at the next falling edge. The monitor bit is due two edges after osc_stopped changes. The flag and stop_irq are due three edges after, and stop_irq drops one edge later. The bench checks at each of these falling edges and also one edge before, to catch early or late results. For the priority case the clearing write is placed so that its strobe falls on the third edge, the same edge as the event.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;
    typedef struct packed {
        logic pll_stop;
        logic det_en;
    } ctrl_t;

    typedef struct packed {
        logic prev;
        logic flag;
        logic irq;
    } det_t;

    localparam int unsigned DATA_W = 8;
endpackage

// File: rtl/clkctl_sync.sv
module clkctl_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/clkctl_stop_det.sv
module clkctl_stop_det
    import clkctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    input  logic enable,
    input  logic clr,
    output logic flag,
    output logic irq
);
    det_t st_d, st_q;
    logic event_w;

    always_comb begin
        event_w    = enable && level && !st_q.prev;
        st_d       = st_q;
        st_d.prev  = level;
        st_d.irq   = event_w;
        if (event_w)  st_d.flag = 1'b1;   // hardware set wins
        else if (clr) st_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag = st_q.flag;
    assign irq  = st_q.irq;
endmodule

// File: rtl/clkctl_regs.sv
module clkctl_regs
    import clkctl_pkg::*;
#(
    parameter int unsigned     ADDR_W    = 20,
    parameter logic [ADDR_W-1:0] PLL_ADDR = 20'h40047,
    parameter logic [ADDR_W-1:0] DET_ADDR = 20'h4004D,
    parameter int unsigned     SYNC_STG  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              wr_unlock,
    input  logic              chg_lock,
    input  logic              pll_is_base,
    input  logic              osc_stopped,
    output logic              pll_en,
    output logic              stop_irq
);
    ctrl_t st_d, st_q;
    logic  sel_pll, sel_det, wr_ok, mon, flag, clr_req;
    logic  pll_stop_q, det_en_q;
    logic  unused_wdata;

    assign unused_wdata = ^{bus_wdata[7:3], bus_wdata[1]};
    assign sel_pll = (bus_addr == PLL_ADDR);
    assign sel_det = (bus_addr == DET_ADDR);
    assign wr_ok   = bus_we && wr_unlock;
    assign clr_req = wr_ok && sel_det && !bus_wdata[2];

    always_comb begin
        st_d = st_q;
        if (wr_ok && !chg_lock) begin
            if (sel_pll) st_d.pll_stop = bus_wdata[0];
            if (sel_det) st_d.det_en   = bus_wdata[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    clkctl_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(osc_stopped), .dout(mon)
    );

    clkctl_stop_det u_det (
        .clk(clk), .rst_n(rst_n), .level(mon), .enable(st_q.det_en),
        .clr(clr_req), .flag(flag), .irq(stop_irq)
    );

    always_comb begin
        bus_rdata = '0;
        if (sel_pll)      bus_rdata = {2'b00, 1'b1, 4'b0000, st_q.pll_stop};
        else if (sel_det) bus_rdata = {4'b0000, mon, flag, 1'b0, st_q.det_en};
    end

    assign pll_en     = !st_q.pll_stop || pll_is_base;
    assign pll_stop_q = st_q.pll_stop;
    assign det_en_q   = st_q.det_en;
endmodule

// File: rtl/clkctl_regs_chk.sv
module clkctl_regs_chk (
    input logic clk,
    input logic rst_n,
    input logic wr_unlock,
    input logic chg_lock,
    input logic pll_is_base,
    input logic pll_en,
    input logic stop_irq,
    input logic pll_stop,
    input logic det_en,
    input logic flag
);
    p_base_keeps_pll_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pll_is_base |-> pll_en);
    p_protect_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_unlock |=> $stable(pll_stop) && $stable(det_en) && !$fell(flag));
    p_lock_r5: assert property (@(posedge clk) disable iff (!rst_n)
        chg_lock |=> $stable(pll_stop) && $stable(det_en));
    p_irq_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        stop_irq |=> !stop_irq);
    p_flag_needs_event_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> stop_irq);
    p_irq_sets_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stop_irq |-> flag);
    p_irq_needs_enable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        stop_irq |-> $past(det_en));
endmodule

bind clkctl_regs clkctl_regs_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wr_unlock(wr_unlock), .chg_lock(chg_lock),
    .pll_is_base(pll_is_base), .pll_en(pll_en), .stop_irq(stop_irq),
    .pll_stop(pll_stop_q), .det_en(det_en_q), .flag(flag)
);

// File: tb/clkctl_regs_test.sv
module clkctl_regs_test;
    localparam logic [19:0] A_PLL = 20'h40047;
    localparam logic [19:0] A_DET = 20'h4004D;

    logic clk = 0, rst_n = 0;
    logic [19:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0, bus_rdata;
    logic bus_we = 0, wr_unlock = 0, chg_lock = 0, pll_is_base = 0, osc_stopped = 0;
    logic pll_en, stop_irq;
    int checks = 0, errors = 0;
    logic [7:0] rv;

    always #5 clk = ~clk;

    clkctl_regs uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .wr_unlock(wr_unlock),
        .chg_lock(chg_lock), .pll_is_base(pll_is_base), .osc_stopped(osc_stopped),
        .pll_en(pll_en), .stop_irq(stop_irq)
    );

    // {is_det, wdata, unlock, lock, exp_pll, exp_det}
    localparam logic [26:0] VEC [7] = '{
        {1'b0, 8'h01, 1'b1, 1'b0, 8'h21, 8'h00},  // R5 unlocked write sets stop
        {1'b0, 8'h00, 1'b0, 1'b0, 8'h21, 8'h00},  // R4 protected, ignored
        {1'b1, 8'h01, 1'b1, 1'b1, 8'h21, 8'h00},  // R5 locked enable
        {1'b1, 8'h01, 1'b1, 1'b0, 8'h21, 8'h01},  // R5 enable set
        {1'b0, 8'h00, 1'b1, 1'b1, 8'h21, 8'h01},  // R5 locked stop bit
        {1'b0, 8'hFE, 1'b1, 1'b0, 8'h20, 8'h01},  // R2 reserved bits fixed
        {1'b1, 8'hFF, 1'b1, 1'b0, 8'h20, 8'h01}   // R6 write 1 to flag no set
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [19:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1;
        @(negedge clk);
        bus_we = 0;
    endtask

    task automatic rd(input logic [19:0] a, output logic [7:0] d);
        bus_addr = a; #1; d = bus_rdata;
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        rd(A_PLL, rv); chk("R1 pll reset", rv, 8'h20);
        rd(A_DET, rv); chk("R1 det reset", rv, 8'h00);
        rd(20'h40048, rv); chk("R1 unmapped", rv, 8'h00);
        chk("R3 pll_en reset", {7'b0, pll_en}, 8'h01);

        for (int i = 0; i < 7; i++) begin
            wr_unlock = VEC[i][17]; chg_lock = VEC[i][16];
            wr(VEC[i][26] ? A_DET : A_PLL, VEC[i][25:18]);
            rd(A_PLL, rv); chk($sformatf("R4/R5 vec%0d pll", i), rv, VEC[i][15:8]);
            rd(A_DET, rv); chk($sformatf("R4/R5 vec%0d det", i), rv, VEC[i][7:0]);
        end
        chg_lock = 0; wr_unlock = 1;

        // R3
        wr(A_PLL, 8'h01);
        chk("R3 stop and not base", {7'b0, pll_en}, 8'h00);
        pll_is_base = 1; #1;
        chk("R3 base overrides stop", {7'b0, pll_en}, 8'h01);
        pll_is_base = 0;

        // R7/R9 stop event timing
        @(negedge clk); osc_stopped = 1;
        @(negedge clk);
        rd(A_DET, rv); chk("R9 monitor after 1 edge", rv, 8'h01);
        @(negedge clk);
        rd(A_DET, rv); chk("R9 monitor after 2 edges", rv, 8'h09);
        chk("R7 irq not early", {7'b0, stop_irq}, 8'h00);
        @(negedge clk);
        rd(A_DET, rv); chk("R7 flag set", rv, 8'h0D);
        chk("R7 irq pulse", {7'b0, stop_irq}, 8'h01);
        @(negedge clk);
        chk("R7 irq one cycle", {7'b0, stop_irq}, 8'h00);

        // R4 clear without unlock ignored
        wr_unlock = 0; wr(A_DET, 8'h01); wr_unlock = 1;
        rd(A_DET, rv); chk("R4 protected clear", rv, 8'h0D);

        // R6/R8 clear under lock while stopped
        chg_lock = 1; wr(A_DET, 8'h00); chg_lock = 0;
        rd(A_DET, rv); chk("R6 clear under lock", rv, 8'h09);
        repeat (5) @(negedge clk);
        rd(A_DET, rv); chk("R8 no re-set while stopped", rv, 8'h09);

        // R8 new event after fall
        osc_stopped = 0; repeat (4) @(negedge clk);
        osc_stopped = 1; repeat (3) @(negedge clk);
        rd(A_DET, rv); chk("R8 new event sets", rv, 8'h0D);

        // R10 clear same cycle as event
        wr(A_DET, 8'h01);
        osc_stopped = 0; repeat (4) @(negedge clk);
        osc_stopped = 1;
        @(negedge clk);
        bus_addr = A_DET; bus_wdata = 8'h01;
        @(negedge clk);
        bus_we = 1;
        @(negedge clk);
        bus_we = 0;
        rd(A_DET, rv); chk("R10 set beats clear", rv, 8'h0D);

        // R11 detection disabled
        wr(A_DET, 8'h00);
        osc_stopped = 0; repeat (4) @(negedge clk);
        osc_stopped = 1;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            chk("R11 no irq", {7'b0, stop_irq}, 8'h00);
        end
        rd(A_DET, rv); chk("R11 no flag", rv, 8'h08);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule